// File: doc/BRIEF.md
# Periodic Stall Pacer for a 66-bit Block Gearbox

This block sits between a source of 66-bit line blocks (64 payload bits plus a 2-bit sync header) and a synchronous gearbox that packs those blocks into a narrower transceiver word. The gearbox takes a block on most cycles of a fixed repeating pattern but cannot accept one on a few set cycles. The pacer steps a position counter through that pattern. On each stall position it withholds the block and pauses the upstream source. On every other position it passes exactly one block, with both qualifiers high. A start flag goes with the output slot for position zero, so the gearbox can align its own phase to the pattern.

The pattern length and the stall positions are parameters. The stall positions form a bitmask as wide as the largest supported pattern. At elaboration the block checks that the bitmask fits the pattern length and that the gearbox rate equation holds: gearbox input width × pattern length = 66 × (pattern length − number of stalls). The defaults are a 33-cycle pattern with one stall and a 64-bit gearbox word. A run-time configuration input turns pacing off, so every enabled cycle carries a block. A clock enable freezes the whole block.

Top module: `gbx_tx_pacer`

## Requirements
- R1: On each cycle with `clk_en` and `gbx_en` high, the position counter moves on by one modulo `SEQ_LEN`. With pacing on, consecutive `out_start` pulses are therefore exactly `SEQ_LEN` enabled cycles apart.
- R2: While `clk_en` is low, `up_ready` is low and every output register and the position counter keep their values.
- R3: `out_start` is high in the output slot produced from position 0, and low in every other slot.
- R4: An enabled cycle at a stall position (bit p of `STALL_MASK` set, with pacing on) drives `up_ready` low. The output slot that follows has `out_data` = 0, `out_hdr` = 0, and both `out_data_valid` and `out_hdr_valid` low.
- R5: An enabled cycle at a non-stall position drives `up_ready` high. If `up_valid` is high, the following slot carries `up_data`/`up_hdr` with both valid outputs high.
- R6: An enabled non-stall cycle with `up_valid` low produces an idle control block: `out_hdr` = 2'b10, `out_data` = 64'h000000000000001E (block type byte in bits 7:0, all idle characters zero), and both valid outputs high.
- R7: While `gbx_en` is low, the position counter stays at 0, `out_start` stays low, and each enabled cycle carries a valid block with `up_ready` high. When pacing is turned back on, the first enabled slot is position 0.
- R8: Reset (`rst_n` low, asynchronous) clears all outputs to zero and sets the position counter to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Clock enable; the whole block holds while low |
| gbx_en | input | 1 | 1: apply the stall pattern; 0: pass a block on every enabled cycle |
| up_data | input | 64 | Upstream block payload |
| up_hdr | input | 2 | Upstream block sync header |
| up_valid | input | 1 | Upstream block present |
| up_ready | output | 1 | Block taken this cycle when up_valid is also high |
| out_data | output | 64 | Block payload to the gearbox |
| out_data_valid | output | 1 | Payload qualifier |
| out_hdr | output | 2 | Sync header to the gearbox |
| out_hdr_valid | output | 1 | Header qualifier |
| out_start | output | 1 | Marks the slot for pattern position 0 |

## Verification
The assertions need a known reset and defined levels on `clk_en` and `gbx_en` at every edge. They do not depend on when upstream blocks arrive. The stall-slot property is written in terms of the block's internal position, so it does not assume the source honours `up_ready`. The stimulus meets these conditions: it drives every input only at the falling edge, runs a full reset before the first step, and changes `gbx_en` only between whole test phases. The bench model treats a block as consumed only on cycles where it expects `up_ready` to be high.

// File: rtl/gbx_pacer_pkg.sv
package gbx_pacer_pkg;

   localparam int          BLK_DATA_W = 64;
   localparam int          BLK_HDR_W  = 2;
   localparam int          BLK_BITS   = BLK_DATA_W + BLK_HDR_W;
   localparam logic [1:0]  HDR_CTRL   = 2'b10;
   localparam logic [63:0] IDLE_DATA  = 64'h0000_0000_0000_001E;

   typedef struct packed {
      logic [BLK_HDR_W-1:0]  hdr;
      logic [BLK_DATA_W-1:0] data;
   } blk_t;

   function automatic int mask_weight(input logic [63:0] m);
      int n;
      n = 0;
      for (int i = 0; i < 64; i++) n += int'(m[i]);
      return n;
   endfunction

endpackage

// File: rtl/gbx_seq_ctr.sv
module gbx_seq_ctr #(
   parameter int SEQ_LEN = 33,
   parameter int CNT_W   = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             run,
   output logic [CNT_W-1:0] pos
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(SEQ_LEN - 1);

   logic [CNT_W-1:0] nxt;

   generate
      if ((1 << CNT_W) == SEQ_LEN) begin : g_wrap_free
         assign nxt = pos + 1'b1;
      end else begin : g_wrap_cmp
         assign nxt = (pos == LAST) ? '0 : pos + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pos <= '0;
      else if (step) pos <= run ? nxt : '0;
   end

endmodule

// File: rtl/gbx_stall_lookup.sv
module gbx_stall_lookup #(
   parameter int                 SEQ_MAX    = 64,
   parameter int                 CNT_W      = 6,
   parameter logic [SEQ_MAX-1:0] STALL_MASK = '0
) (
   input  logic [CNT_W-1:0] pos,
   input  logic             run,
   output logic             stall
);

   logic [SEQ_MAX-1:0] hit;

   generate
      for (genvar g = 0; g < SEQ_MAX; g++) begin : g_pos
         if (STALL_MASK[g]) begin : g_on
            assign hit[g] = (pos == CNT_W'(g));
         end else begin : g_off
            assign hit[g] = 1'b0;
         end
      end
   endgenerate

   assign stall = run & (|hit);

endmodule

// File: rtl/gbx_blk_register.sv
module gbx_blk_register
   import gbx_pacer_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  step,
   input  logic                  stall,
   input  logic                  first,
   input  blk_t                  blk_in,
   output logic [BLK_DATA_W-1:0] data_o,
   output logic [BLK_HDR_W-1:0]  hdr_o,
   output logic                  data_vld_o,
   output logic                  hdr_vld_o,
   output logic                  start_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o     <= '0;
         hdr_o      <= '0;
         data_vld_o <= 1'b0;
         hdr_vld_o  <= 1'b0;
         start_o    <= 1'b0;
      end else if (step) begin
         start_o    <= first;
         data_vld_o <= ~stall;
         hdr_vld_o  <= ~stall;
         data_o     <= stall ? '0 : blk_in.data;
         hdr_o      <= stall ? '0 : blk_in.hdr;
      end
   end

endmodule

// File: rtl/gbx_tx_pacer.sv
module gbx_tx_pacer
   import gbx_pacer_pkg::*;
#(
   parameter int                 SEQ_MAX    = 64,
   parameter int                 SEQ_LEN    = 33,
   parameter logic [SEQ_MAX-1:0] STALL_MASK = SEQ_MAX'(64'h20),
   parameter int                 GBX_IN_W   = 64
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clk_en,
   input  logic        gbx_en,
   input  logic [63:0] up_data,
   input  logic [1:0]  up_hdr,
   input  logic        up_valid,
   output logic        up_ready,
   output logic [63:0] out_data,
   output logic        out_data_valid,
   output logic [1:0]  out_hdr,
   output logic        out_hdr_valid,
   output logic        out_start
);

   localparam int CNT_W     = (SEQ_MAX > 1) ? $clog2(SEQ_MAX) : 1;
   localparam int STALL_CNT = mask_weight(64'(STALL_MASK));

   generate
      if (SEQ_MAX < 1 || SEQ_MAX > 64) begin : g_bad_max
         $error("SEQ_MAX must be within 1..64");
      end
      if (SEQ_LEN < 1 || SEQ_LEN > SEQ_MAX) begin : g_bad_len
         $error("SEQ_LEN must be within 1..SEQ_MAX");
      end
      if ((64'(STALL_MASK) >> SEQ_LEN) != 64'd0) begin : g_bad_mask
         $error("STALL_MASK has a bit at or above SEQ_LEN");
      end
      if (STALL_CNT >= SEQ_LEN) begin : g_bad_cnt
         $error("pattern needs at least one passing position");
      end
      if (GBX_IN_W * SEQ_LEN != BLK_BITS * (SEQ_LEN - STALL_CNT)) begin : g_bad_ratio
         $error("gearbox rate equation does not balance");
      end
   endgenerate

   logic [CNT_W-1:0] seq_pos;
   logic             slot_stall;
   blk_t             in_blk;

   gbx_seq_ctr #(
      .SEQ_LEN (SEQ_LEN),
      .CNT_W   (CNT_W)
   ) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (clk_en),
      .run   (gbx_en),
      .pos   (seq_pos)
   );

   gbx_stall_lookup #(
      .SEQ_MAX    (SEQ_MAX),
      .CNT_W      (CNT_W),
      .STALL_MASK (STALL_MASK)
   ) u_lut (
      .pos   (seq_pos),
      .run   (gbx_en),
      .stall (slot_stall)
   );

   assign up_ready = clk_en & ~slot_stall;

   always_comb begin
      if (up_valid) begin
         in_blk.hdr  = up_hdr;
         in_blk.data = up_data;
      end else begin
         in_blk.hdr  = HDR_CTRL;
         in_blk.data = IDLE_DATA;
      end
   end

   gbx_blk_register u_reg (
      .clk        (clk),
      .rst_n      (rst_n),
      .step       (clk_en),
      .stall      (slot_stall),
      .first      (gbx_en && (seq_pos == '0)),
      .blk_in     (in_blk),
      .data_o     (out_data),
      .hdr_o      (out_hdr),
      .data_vld_o (out_data_valid),
      .hdr_vld_o  (out_hdr_valid),
      .start_o    (out_start)
   );

endmodule

// File: rtl/gbx_tx_pacer_chk.sv
module gbx_tx_pacer_chk #(
   parameter int                 SEQ_MAX    = 64,
   parameter int                 SEQ_LEN    = 33,
   parameter logic [SEQ_MAX-1:0] STALL_MASK = '0,
   parameter int                 CNT_W      = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clk_en,
   input logic             gbx_en,
   input logic             up_ready,
   input logic [63:0]      out_data,
   input logic             out_data_valid,
   input logic [1:0]       out_hdr,
   input logic             out_hdr_valid,
   input logic             out_start,
   input logic [CNT_W-1:0] pos
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(SEQ_LEN - 1);

   AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      pos <= LAST);  // R1

   AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en && gbx_en |=> pos == (($past(pos) == LAST) ? '0 : $past(pos) + 1'b1));  // R1

   AST_HOLD_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |=> $stable(pos) && $stable(out_data) && $stable(out_hdr)
                  && $stable(out_data_valid) && $stable(out_hdr_valid) && $stable(out_start));  // R2

   AST_READY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      up_ready |-> clk_en);  // R2

   AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en && gbx_en && pos == '0 |=> out_start);  // R3

   AST_START_ELSEWHERE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en && !(gbx_en && pos == '0) |=> !out_start);  // R3

   AST_STALL_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en && gbx_en && STALL_MASK[pos] |=> !out_data_valid && out_data == '0 && out_hdr == '0);  // R4

   AST_QUAL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      out_data_valid == out_hdr_valid);  // R5

   AST_BYPASS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en && !gbx_en |=> out_data_valid && !out_start && pos == '0);  // R7

endmodule

bind gbx_tx_pacer gbx_tx_pacer_chk #(
   .SEQ_MAX    (SEQ_MAX),
   .SEQ_LEN    (SEQ_LEN),
   .STALL_MASK (STALL_MASK),
   .CNT_W      (CNT_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .clk_en         (clk_en),
   .gbx_en         (gbx_en),
   .up_ready       (up_ready),
   .out_data       (out_data),
   .out_data_valid (out_data_valid),
   .out_hdr        (out_hdr),
   .out_hdr_valid  (out_hdr_valid),
   .out_start      (out_start),
   .pos            (seq_pos)
);

// File: tb/sim_gbx_tx_pacer.sv
module sim_gbx_tx_pacer;

   localparam int          L       = 33;
   localparam int          STALL_P = 5;
   localparam logic [63:0] MASK    = 64'h1 << STALL_P;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clk_en = 1'b0;
   logic        gbx_en = 1'b0;
   logic [63:0] up_data = '0;
   logic [1:0]  up_hdr = '0;
   logic        up_valid = 1'b0;
   logic        up_ready;
   logic [63:0] out_data;
   logic        out_data_valid;
   logic [1:0]  out_hdr;
   logic        out_hdr_valid;
   logic        out_start;

   int total = 0;
   int bad   = 0;

   int          e_pos = 0;
   logic [63:0] e_data = '0;
   logic [1:0]  e_hdr = '0;
   logic        e_vld = 1'b0;
   logic        e_start = 1'b0;
   int          since = 0;
   bit          seen = 1'b0;

   always #10 clk = ~clk;

   gbx_tx_pacer #(
      .SEQ_MAX    (64),
      .SEQ_LEN    (L),
      .STALL_MASK (MASK),
      .GBX_IN_W   (64)
   ) u0 (
      .clk            (clk),
      .rst_n          (rst_n),
      .clk_en         (clk_en),
      .gbx_en         (gbx_en),
      .up_data        (up_data),
      .up_hdr         (up_hdr),
      .up_valid       (up_valid),
      .up_ready       (up_ready),
      .out_data       (out_data),
      .out_data_valid (out_data_valid),
      .out_hdr        (out_hdr),
      .out_hdr_valid  (out_hdr_valid),
      .out_start      (out_start)
   );

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic bit is_stall(input int p);
      return MASK[p];
   endfunction

   task automatic step(input bit ce, input bit ge, input bit uv, input logic [63:0] d, input logic [1:0] h);
      string tag;
      bit    st;
      clk_en = ce; gbx_en = ge; up_valid = uv; up_data = d; up_hdr = h;
      st = ge && is_stall(e_pos);
      #1;
      tag = !ce ? "R2" : (!ge ? "R7" : (st ? "R4" : "R5"));
      chk(tag, "up_ready", 64'(up_ready), 64'(ce && !st));
      @(posedge clk);
      @(negedge clk);
      if (ce) begin
         e_start = ge && (e_pos == 0);
         e_vld   = !st;
         if (st) begin
            e_data = '0; e_hdr = '0;
         end else if (uv) begin
            e_data = d; e_hdr = h;
         end else begin
            e_data = 64'h1E; e_hdr = 2'b10;
         end
         e_pos = ge ? ((e_pos + 1) % L) : 0;
      end
      if (!ce)         tag = "R2";
      else if (!ge)    tag = "R7";
      else if (st)     tag = "R4";
      else if (!uv)    tag = "R6";
      else             tag = "R5";
      chk(tag, "out_data", out_data, e_data);
      chk(tag, "out_hdr", 64'(out_hdr), 64'(e_hdr));
      chk(tag, "out_data_valid", 64'(out_data_valid), 64'(e_vld));
      chk(tag, "out_hdr_valid", 64'(out_hdr_valid), 64'(e_vld));
      chk(!ce ? "R2" : (!ge ? "R7" : "R3"), "out_start", 64'(out_start), 64'(e_start));
      if (!ge) begin
         seen = 1'b0; since = 0;
      end else if (ce) begin
         since++;
         if (out_start) begin
            if (seen) chk("R1", "start spacing", 64'(since), 64'(L));
            seen = 1'b1; since = 0;
         end
      end
   endtask

   function automatic logic [63:0] pat(input int k);
      return {32'(k) * 32'h9E37_79B1, ~32'(k)};
   endfunction

   initial begin
      #4_000_000;
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R8: reset state
      chk("R8", "out_data", out_data, 64'h0);
      chk("R8", "out_hdr", 64'(out_hdr), 64'h0);
      chk("R8", "out_data_valid", 64'(out_data_valid), 64'h0);
      chk("R8", "out_hdr_valid", 64'(out_hdr_valid), 64'h0);
      chk("R8", "out_start", 64'(out_start), 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 R3 R4 R5: steady pacing, source always ready
      for (int k = 0; k < 3 * L + 4; k++) step(1'b1, 1'b1, 1'b1, pat(k), 2'(1 + (k & 1)));
      // R2 R6: gaps in enable and source
      for (int k = 0; k < 220; k++)
         step(($urandom % 4) != 0, 1'b1, ($urandom % 10) < 7, pat(1000 + k), 2'($urandom));
      // R7: pacing off
      for (int k = 0; k < 45; k++)
         step(($urandom % 5) != 0, 1'b0, ($urandom % 3) != 0, pat(2000 + k), 2'($urandom));
      // R7: pacing back on restarts at position 0
      for (int k = 0; k < 2 * L + 3; k++) step(1'b1, 1'b1, 1'b1, pat(3000 + k), 2'b01);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule